// File: doc/BRIEF.md
# Reference Clock Switchover Controller

This block picks which of three clock sources drives a downstream phase detector: reference A, reference B, or a local crystal path. Each source has an activity monitor. The monitor counts that source's rising edges over a fixed window of a free-running monitor clock and flags the source as faulty when too few edges arrive. A selection state machine runs in the monitor domain. When the active reference dies, it moves to the other reference, in either direction. It falls back to the crystal (holdover) only when both references are gone and the crystal itself shows activity.

A configuration input selects a differential reference arrangement. In that arrangement only reference A carries a clock: reference B is never chosen and its fault flag reads as clear. Once the controller has failed over it stays on the new reference, unless a manual force input names another valid source. The chosen source reaches the clock output through a glitch-free mux. The mux drops the old source's enable while that clock is low and raises the new one's enable while the new clock is low. Each enable passes through two flops clocked on the falling edge of its own source clock.

Top module: `refclk_switchover`

## Requirements
- R1: While reset is held and until the first monitor window completes, `sel_o` reads 2'b00 (reference A), `holdover_o` is 0 and all three fault flags read 1; during reset `clk_out` is held at 0.
- R2: At the end of every window of WIN_CYCLES monitor cycles, a source's fault flag is set if fewer than MIN_EDGES of its rising edges were counted in that window, and cleared otherwise.
- R3: With reference A selected, no force active and A faulty while B is valid, the selection moves to B (`sel_o` = 2'b01) on the next monitor cycle.
- R4: With reference B selected, no force active and B faulty while A is valid, the selection moves to A (`sel_o` = 2'b00) on the next monitor cycle.
- R5: Switching is non-revertive: while B is selected, valid and not forced away, the selection stays on B even when A is valid.
- R6: When the selected reference fails, the other reference is unavailable and the crystal is valid, the crystal is selected (`sel_o` = 2'b10) and `holdover_o` reads 1. `holdover_o` is 1 exactly when the crystal is selected.
- R7: If the crystal is also faulty, holdover is not entered and the selection stays where it was.
- R8: While on the crystal, the first reference to become valid is selected. If A and B become valid in the same window, A is chosen.
- R9: When `diff_mode` is 1, reference B is treated as unavailable: it is never selected, it cannot be forced, and `fault_b_o` reads 0.
- R10: With `force_en` = 1, `force_sel` (00 = A, 01 = B, 10 = crystal) selects that source if it is valid. A force naming an invalid source has no effect, and the automatic rules apply.
- R11: After a change of selection settles, `clk_out` equals the selected source clock. At no time are two source enables active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock |
| mon_rst_n | input | 1 | Asynchronous active-low reset |
| clk_a | input | 1 | Reference A clock |
| clk_b | input | 1 | Reference B clock |
| clk_x | input | 1 | Crystal path clock |
| diff_mode | input | 1 | 1 = single differential reference on A, B unused |
| force_en | input | 1 | Manual selection enable |
| force_sel | input | 2 | Manual source: 00 A, 01 B, 10 crystal |
| clk_out | output | 1 | Glitch-free selected clock |
| sel_o | output | 2 | Current selection: 00 A, 01 B, 10 crystal |
| holdover_o | output | 1 | Crystal path selected |
| fault_a_o | output | 1 | Reference A inactive |
| fault_b_o | output | 1 | Reference B inactive (0 in differential mode) |
| fault_x_o | output | 1 | Crystal path inactive |

## Verification
Assertions check the following on every monitor cycle:
- B is never chosen in differential mode.
- Holdover is only entered from a valid crystal.
- Both failover directions fire when their conditions hold.
- The controller does not revert to A while B is still good.
- At most one source enable is ever high.

Only the bench scenarios can show the rest:
- Slow or stopped sources really get flagged, and recovered sources get cleared.
- A wins when both references recover together.
- Forces naming dead or disabled sources are ignored.
- `clk_out` ends up tracking the right source clock.

// File: rtl/refclk_switchover.sv
module refclk_switchover #(
  parameter int WIN_CYCLES = 64,
  parameter int MIN_EDGES  = 4
) (
  input  logic       mon_clk,
  input  logic       mon_rst_n,
  input  logic       clk_a,
  input  logic       clk_b,
  input  logic       clk_x,
  input  logic       diff_mode,
  input  logic       force_en,
  input  logic [1:0] force_sel,
  output logic       clk_out,
  output logic [1:0] sel_o,
  output logic       holdover_o,
  output logic       fault_a_o,
  output logic       fault_b_o,
  output logic       fault_x_o
);

  localparam int WW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam int CW = $clog2(MIN_EDGES + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYCLES - 1);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_EDGES);
  localparam logic [1:0] SEL_A = 2'd0, SEL_B = 2'd1, SEL_X = 2'd2;

  logic [2:0]    src_clk, valid, en_s2;
  logic [WW-1:0] win_q;
  logic          win_end;
  logic [1:0]    sel_q, sel_d;

  assign src_clk = {clk_x, clk_b, clk_a};
  assign win_end = (win_q == WIN_LAST);

  always_ff @(posedge mon_clk or negedge mon_rst_n)
    if (!mon_rst_n) win_q <= '0;
    else            win_q <= win_end ? '0 : win_q + 1'b1;

  for (genvar i = 0; i < 3; i++) begin : g_src
    wire sclk = src_clk[i];
    logic tg, m1, m2, m3, vq, s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge sclk or negedge mon_rst_n)
      if (!mon_rst_n) tg <= 1'b0;
      else            tg <= ~tg;

    always_ff @(posedge mon_clk or negedge mon_rst_n)
      if (!mon_rst_n) begin
        {m1, m2, m3} <= '0;
        cnt <= '0;
        vq  <= 1'b0;
      end else begin
        {m1, m2, m3} <= {tg, m1, m2};
        if (win_end) begin
          vq  <= (cnt >= MIN_C);
          cnt <= '0;
        end else if ((m2 ^ m3) && cnt != MIN_C) begin
          cnt <= cnt + 1'b1;
        end
      end

    assign valid[i] = vq;

    wire req  = (sel_q == 2'(i)) && ((en_s2 & ~(3'b001 << i)) == 3'b000);
    wire kill = !mon_rst_n || !vq;

    always_ff @(negedge sclk or posedge kill)
      if (kill) {s1, s2} <= 2'b00;
      else      {s1, s2} <= {req, s1};

    assign en_s2[i] = s2;
  end

  wire va = valid[0];
  wire vb = valid[1] && !diff_mode;
  wire vx = valid[2];

  always_comb begin
    sel_d = sel_q;
    if (force_en && force_sel == SEL_A && va)      sel_d = SEL_A;
    else if (force_en && force_sel == SEL_B && vb) sel_d = SEL_B;
    else if (force_en && force_sel == SEL_X && vx) sel_d = SEL_X;
    else begin
      case (sel_q)
        SEL_A:   if (!va) sel_d = vb ? SEL_B : (vx ? SEL_X : SEL_A);
        SEL_B:   if (!vb) sel_d = va ? SEL_A : (vx ? SEL_X : SEL_B);
        default: sel_d = va ? SEL_A : (vb ? SEL_B : SEL_X);
      endcase
    end
  end

  always_ff @(posedge mon_clk or negedge mon_rst_n)
    if (!mon_rst_n) sel_q <= SEL_A;
    else            sel_q <= sel_d;

  assign clk_out    = |(src_clk & en_s2);
  assign sel_o      = sel_q;
  assign holdover_o = (sel_q == SEL_X);
  assign fault_a_o  = !valid[0];
  assign fault_b_o  = !valid[1] && !diff_mode;
  assign fault_x_o  = !valid[2];

  // R3
  fail_ab_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
    (sel_q == SEL_A && !valid[0] && valid[1] && !diff_mode && !force_en) |=> sel_q == SEL_B);

  // R4
  fail_ba_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
    (sel_q == SEL_B && (!valid[1] || diff_mode) && valid[0] && !force_en) |=> sel_q == SEL_A);

  // R5
  no_revert_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
    (sel_q == SEL_B && valid[1] && !diff_mode && !force_en) |=> sel_q == SEL_B);

  // R6
  hold_entry_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
    $rose(holdover_o) |-> $past(valid[2]));

  // R9
  diff_no_b_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
    $past(diff_mode) |-> sel_o != SEL_B);

  // R11
  one_enable_chk: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
    $onehot0(en_s2));

endmodule

// File: tb/refclk_switchover_tb_top.sv
`timescale 1ns/1ps
module refclk_switchover_tb_top;
  logic mon_clk = 1'b0, mon_rst_n = 1'b0;
  logic clk_a, clk_b, clk_x;
  logic a_on = 1'b1, b_on = 1'b1, x_on = 1'b1, a_slow = 1'b0;
  logic diff_mode = 1'b0, force_en = 1'b0;
  logic [1:0] force_sel = 2'b00;
  logic clk_out, holdover_o, fault_a_o, fault_b_o, fault_x_o;
  logic [1:0] sel_o;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  refclk_switchover dut_i (
    .mon_clk(mon_clk), .mon_rst_n(mon_rst_n),
    .clk_a(clk_a), .clk_b(clk_b), .clk_x(clk_x),
    .diff_mode(diff_mode), .force_en(force_en), .force_sel(force_sel),
    .clk_out(clk_out), .sel_o(sel_o), .holdover_o(holdover_o),
    .fault_a_o(fault_a_o), .fault_b_o(fault_b_o), .fault_x_o(fault_x_o));

  always #2 mon_clk = ~mon_clk;

  initial begin clk_a = 1'b0; #1; forever begin #(a_slow ? 50 : 10); clk_a = a_on ? ~clk_a : 1'b0; end end
  initial begin clk_b = 1'b0; #1; forever begin #12; clk_b = b_on ? ~clk_b : 1'b0; end end
  initial begin clk_x = 1'b0; #1; forever begin #14; clk_x = x_on ? ~clk_x : 1'b0; end end

  // {a,b,x,diff,force_en,force_sel[2], exp_sel[2],exp_hold,exp_fa,exp_fb,exp_fx, req[4]}
  localparam int NV = 14;
  localparam logic [16:0] VEC [NV] = '{
    17'b1_1_1_0_0_00_00_0_0_0_0_0010, // R2 all sources active
    17'b0_1_1_0_0_00_01_0_1_0_0_0011, // R3 A dies
    17'b1_1_1_0_0_00_01_0_0_0_0_0101, // R5 A returns, stay on B
    17'b1_0_1_0_0_00_00_0_0_1_0_0100, // R4 B dies
    17'b0_1_1_0_0_00_01_0_1_0_0_0011, // R3 A dies again
    17'b0_0_1_0_0_00_10_1_1_1_0_0110, // R6 both refs gone
    17'b1_1_1_0_0_00_00_0_0_0_0_1000, // R8 both recover, A preferred
    17'b1_1_1_0_1_01_01_0_0_0_0_1010, // R10 force B
    17'b1_1_1_0_1_10_10_1_0_0_0_1010, // R10 force crystal
    17'b1_1_1_0_0_00_00_0_0_0_0_1000, // R8 release force, leave crystal for A
    17'b0_1_1_1_0_00_10_1_1_0_0_1001, // R9 diff mode, A dies, B ignored
    17'b1_1_1_1_0_00_00_0_0_0_0_1001, // R9 A back
    17'b1_1_1_1_1_01_00_0_0_0_0_1010, // R10 force B ignored in diff mode
    17'b0_1_1_0_0_00_01_0_1_0_0_0011  // R3 single-ended again, A dies
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {sel,hold,fa,fb,fx} got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_status(input string tag, input logic [1:0] s, input logic h,
                            input logic fa, input logic fb, input logic fx);
    chk(tag, {sel_o, holdover_o, fault_a_o, fault_b_o, fault_x_o}, {s, h, fa, fb, fx});
  endtask

  task automatic chk_clk(input string tag, input logic [1:0] s);
    int bad = 0;
    for (int j = 0; j < 64; j++) begin
      @(negedge mon_clk);
      if (clk_out !== ((s == 2'd0) ? clk_a : (s == 2'd1) ? clk_b : clk_x)) bad++;
    end
    n_cmp++;
    if (bad != 0) begin
      n_bad++;
      $display("FAIL %s: clk_out differs from selected source in %0d of 64 samples, expected 0", tag, bad);
    end
  endtask

  task automatic settle();
    repeat (220) @(negedge mon_clk);
  endtask

  initial begin
    repeat (100000) @(posedge mon_clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (8) @(negedge mon_clk);
    // R1 during reset
    chk_status("R1 in reset", 2'b00, 1'b0, 1'b1, 1'b1, 1'b1);
    n_cmp++;
    if (clk_out !== 1'b0) begin n_bad++; $display("FAIL R1: clk_out got %b expected 0", clk_out); end
    mon_rst_n = 1'b1;
    repeat (5) @(negedge mon_clk);
    chk_status("R1 before first window", 2'b00, 1'b0, 1'b1, 1'b1, 1'b1);

    for (int k = 0; k < NV; k++) begin
      logic [16:0] v;
      v = VEC[k];
      {a_on, b_on, x_on, diff_mode, force_en, force_sel} = v[16:10];
      settle();
      chk_status($sformatf("R%0d row %0d", v[3:0], k), v[9:8], v[7], v[6], v[5], v[4]);
      chk_clk($sformatf("R11 row %0d", k), v[9:8]);
    end

    // R7: every source dead, no holdover, selection unchanged
    b_on = 1'b0; x_on = 1'b0;
    settle();
    chk_status("R7 crystal absent", 2'b01, 1'b0, 1'b1, 1'b1, 1'b1);
    chk_clk("R7 clock parked low", 2'b01);

    // R6: crystal returns, holdover entered
    x_on = 1'b1;
    settle();
    chk_status("R6 crystal returns", 2'b10, 1'b1, 1'b1, 1'b1, 1'b0);
    chk_clk("R11 crystal", 2'b10);

    // R8: both references back together, A wins
    a_on = 1'b1; b_on = 1'b1;
    settle();
    chk_status("R8 joint recovery", 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);

    // R2: A slowed below the edge threshold counts as a fault
    a_slow = 1'b1;
    settle();
    chk_status("R2 slow A flagged", 2'b01, 1'b0, 1'b1, 1'b0, 1'b0);
    chk_clk("R11 after slow A", 2'b01);

    // R2: A back to speed clears its flag; R5 keeps B
    a_slow = 1'b0;
    settle();
    chk_status("R2 A flag cleared", 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);

    finish_run();
  end
endmodule